// File: doc/BRIEF.md
# Two-Level Virtual Address Translator

This block turns a 25-bit word virtual address into a 32-bit byte physical address. It looks the address up in two tables.

- **First-level table.** The top twelve address bits index it. Each entry says whether the address segment is mapped at all. It also carries the segment's garbage-collection attributes and names one block of the second-level table.
- **Second-level table.** It holds 128 blocks of 32 entries. The next five address bits select one entry in the chosen block. That entry supplies the physical page number, an access bit, a three-bit status code, a representation type and a force-allowed flag.

The block then decides whether the request may go ahead. A request is a read, a write or a forced write. When the request cannot go ahead, the block raises an exception with a cause code for the handler.

A host loads both tables through simple write ports. Lookups use a valid/ready request and return exactly one result per accepted request, two cycles later. Lookups are pipelined, so one request can be accepted every cycle.

Top module: `vmap_xlate`

## Requirements
- R1: While reset is low, `req_ready` and `rsp_valid` are 0. `req_ready` is 1 from the first clock edge after reset is released. A request accepted at clock edge T produces `rsp_valid` high for exactly one cycle, after edge T+1.
- R2: The first-level entry is chosen by `req_va[24:13]`. Its layout is: bit 11 valid, bit 10 oldspace (0 means oldspace), bits 9:7 volatility, bits 6:0 second-level block number. When bit 11 is 0, the cause is 1, and `rsp_pa`, `rsp_status` and `rsp_rep` are all 0.
- R3: The second-level entry is chosen by the block number followed by `req_va[12:8]`. The entry's 12-bit write address is {block, entry}. Its layout is: bits 21:0 physical page number, bit 22 access, bits 25:23 status, bits 27:26 representation type, bit 28 force-allowed.
- R4: When the first level is valid, `rsp_pa` is {page number, `req_va[7:0]`, 2'b00}. `rsp_status` and `rsp_rep` show the entry's fields.
- R5: Status 0 gives cause 2 (map miss). Status 1 gives cause 5 (attributes only). Status 5, 6 or 7 gives cause 6 (special page). These causes apply whatever the access bit and the request type.
- R6: For status 2, 3 or 4, the access bit decides reads. Access bit 0 gives cause 3 for any request. Access bit 1 lets a read complete with cause 0.
- R7: A write needs the access code {access, status[2]} to be 3, which means status 4 with access 1. Otherwise, on a page whose access bit is 1, the write gives cause 4.
- R8: A forced write to a read-only page (access 1, status 2 or 3) completes with cause 0 only if the entry's force-allowed bit is 1. Otherwise it gives cause 4.
- R9: `rsp_exc` is 1 exactly when the cause is not 0. `rsp_oldspace` and `rsp_vol` always show the first-level entry's fields.
- R10: A table write made in the cycle before a request is accepted is seen by that request.
- R11: Causes are ranked: first-level miss first, then the status causes of R5, then the access causes of R6 to R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l1_we | input | 1 | First-level table write enable |
| l1_waddr | input | 12 | First-level entry index |
| l1_wdata | input | 12 | First-level entry contents |
| l2_we | input | 1 | Second-level table write enable |
| l2_waddr | input | 12 | Second-level {block, entry} index |
| l2_wdata | input | 29 | Second-level entry contents |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Block can take a request |
| req_va | input | 25 | Word virtual address |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_force | input | 1 | Write is forced |
| rsp_valid | output | 1 | Result valid |
| rsp_pa | output | 32 | Byte physical address |
| rsp_exc | output | 1 | Exception raised |
| rsp_cause | output | 3 | Exception cause code |
| rsp_status | output | 3 | Second-level status code |
| rsp_rep | output | 2 | Representation type |
| rsp_oldspace | output | 1 | Oldspace bit (0 means oldspace) |
| rsp_vol | output | 3 | First-level volatility bits |

## Verification
The assertions assume that every lookup targets first-level and second-level entries that the host has already written. Under that assumption, the table outputs are never unknown when a result is checked. They also assume the request inputs are stable and known during the cycle they are accepted. The stimulus writes both entries behind each address just before looking it up. It drives all inputs away from the clock edge, and it holds `req_valid` low during reset.

// File: rtl/vmap_xlate.sv
module vmap_xlate #(
  parameter int L1_IDX_W = 12,
  parameter int L2_BLK_W = 7,
  parameter int L2_ENT_W = 5,
  parameter int OFF_W    = 8,
  parameter int PPN_W    = 22
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         l1_we,
  input  logic [L1_IDX_W-1:0]          l1_waddr,
  input  logic [L2_BLK_W+4:0]          l1_wdata,
  input  logic                         l2_we,
  input  logic [L2_BLK_W+L2_ENT_W-1:0] l2_waddr,
  input  logic [PPN_W+6:0]             l2_wdata,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [L1_IDX_W+L2_ENT_W+OFF_W-1:0] req_va,
  input  logic                         req_write,
  input  logic                         req_force,
  output logic                         rsp_valid,
  output logic [PPN_W+OFF_W+1:0]       rsp_pa,
  output logic                         rsp_exc,
  output logic [2:0]                   rsp_cause,
  output logic [2:0]                   rsp_status,
  output logic [1:0]                   rsp_rep,
  output logic                         rsp_oldspace,
  output logic [2:0]                   rsp_vol
);
  localparam int VA_W     = L1_IDX_W + L2_ENT_W + OFF_W;
  localparam int L2_IDX_W = L2_BLK_W + L2_ENT_W;
  localparam int L1_W     = L2_BLK_W + 5;
  localparam int L2_W     = PPN_W + 7;
  localparam int PA_W     = PPN_W + OFF_W + 2;
  localparam int L1_V     = L2_BLK_W + 4;
  localparam int L1_OLD   = L2_BLK_W + 3;
  localparam int L2_ACC   = PPN_W;
  localparam int L2_FOK   = PPN_W + 6;

  logic [L1_W-1:0] l1_mem [1<<L1_IDX_W];
  logic [L2_W-1:0] l2_mem [1<<L2_IDX_W];

  logic            ready_q;
  logic            a_vld, a_wr, a_frc;
  logic [VA_W-1:0] a_va;
  logic [L1_W-1:0] a_l1;
  logic            b_vld, b_wr, b_frc;
  logic [OFF_W-1:0] b_off;
  logic [L1_W-1:0] b_l1;
  logic [L2_W-1:0] b_l2;
  logic            accept;

  assign accept    = req_valid && req_ready;
  assign req_ready = ready_q;

  always_ff @(posedge clk) begin
    if (l1_we) l1_mem[l1_waddr] <= l1_wdata;
    if (l2_we) l2_mem[l2_waddr] <= l2_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      a_vld   <= 1'b0;
      b_vld   <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      a_vld   <= accept;
      b_vld   <= a_vld;
    end
  end

  always_ff @(posedge clk) begin
    a_va  <= req_va;
    a_wr  <= req_write;
    a_frc <= req_force;
    a_l1  <= l1_mem[req_va[VA_W-1 -: L1_IDX_W]];
    b_off <= a_va[OFF_W-1:0];
    b_wr  <= a_wr;
    b_frc <= a_frc;
    b_l1  <= a_l1;
    b_l2  <= l2_mem[{a_l1[L2_BLK_W-1:0], a_va[OFF_W +: L2_ENT_W]}];
  end

  logic [2:0] st;
  logic       l1v;
  assign st  = b_l2[PPN_W+3:PPN_W+1];
  assign l1v = b_l1[L1_V];

  always_comb begin
    if (!l1v)                       rsp_cause = 3'd1;
    else if (st == 3'd0)            rsp_cause = 3'd2;
    else if (st == 3'd1)            rsp_cause = 3'd5;
    else if (st >= 3'd5)            rsp_cause = 3'd6;
    else if (!b_l2[L2_ACC])         rsp_cause = 3'd3;
    else if (b_wr && !st[2] && !(b_frc && b_l2[L2_FOK])) rsp_cause = 3'd4;
    else                            rsp_cause = 3'd0;
  end

  assign rsp_valid    = b_vld;
  assign rsp_exc      = (rsp_cause != 3'd0);
  assign rsp_pa       = l1v ? {b_l2[PPN_W-1:0], b_off, 2'b00} : '0;
  assign rsp_status   = l1v ? st : 3'd0;
  assign rsp_rep      = l1v ? b_l2[PPN_W+5:PPN_W+4] : 2'd0;
  assign rsp_oldspace = b_l1[L1_OLD];
  assign rsp_vol      = b_l1[L2_BLK_W+2:L2_BLK_W];

  assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(accept, 2));
  assert_ready_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> req_ready);
  assert_ok_only_mapped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_exc) |-> (rsp_status >= 3'd2 && rsp_status <= 3'd4));
  assert_pa_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_exc && $past(accept, 2)) |-> rsp_pa[OFF_W+1:2] == $past(req_va[OFF_W-1:0], 2));
  assert_l1miss_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_cause == 3'd1) |-> (rsp_pa == '0 && rsp_status == 3'd0));
  assert_write_ok_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_exc && $past(accept && req_write && !req_force, 2)) |-> rsp_status == 3'd4);
endmodule

// File: tb/tb_vmap_xlate.sv
`timescale 1ns/1ps
module tb_vmap_xlate;
  logic clk = 0, rst_n = 0;
  logic l1_we = 0, l2_we = 0;
  logic [11:0] l1_waddr = 0, l2_waddr = 0;
  logic [11:0] l1_wdata = 0;
  logic [28:0] l2_wdata = 0;
  logic req_valid = 0, req_write = 0, req_force = 0;
  logic [24:0] req_va = 0;
  logic req_ready, rsp_valid, rsp_exc, rsp_oldspace;
  logic [31:0] rsp_pa;
  logic [2:0] rsp_cause, rsp_status, rsp_vol;
  logic [1:0] rsp_rep;

  vmap_xlate dut (.*);

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [11:0] m1 [4096];
  logic [28:0] m2 [4096];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  // packs {cause, status, rep, oldspace, vol, pa}
  function automatic logic [43:0] model(input logic [24:0] va, input logic w, input logic f);
    logic [11:0] e1; logic [28:0] e2; logic [2:0] c, st;
    e1 = m1[va[24:13]];
    e2 = m2[{e1[6:0], va[12:8]}];
    st = e2[25:23];
    if (!e1[11])                     c = 3'd1;
    else if (st == 0)                c = 3'd2;
    else if (st == 1)                c = 3'd5;
    else if (st >= 5)                c = 3'd6;
    else if (!e2[22])                c = 3'd3;
    else if (w && st != 4 && !(f && e2[28])) c = 3'd4;
    else                             c = 3'd0;
    if (e1[11])
      return {c, st, e2[27:26], e1[10], e1[9:7], e2[21:0], va[7:0], 2'b00};
    return {c, 3'd0, 2'd0, e1[10], e1[9:7], 32'd0};
  endfunction

  task automatic wr1(input logic [11:0] a, input logic [11:0] d);
    @(negedge clk); l1_we = 1; l1_waddr = a; l1_wdata = d; m1[a] = d;
    @(negedge clk); l1_we = 0;
  endtask

  task automatic wr2(input logic [11:0] a, input logic [28:0] d);
    @(negedge clk); l2_we = 1; l2_waddr = a; l2_wdata = d; m2[a] = d;
    @(negedge clk); l2_we = 0;
  endtask

  // request set at this negedge; accepted at next edge; result after the edge after that
  task automatic look(input logic [24:0] va, input logic w, input logic f, input string tag);
    logic [43:0] e;
    e = model(va, w, f);
    req_valid = 1; req_va = va; req_write = w; req_force = f;
    @(negedge clk); req_valid = 0;
    @(negedge clk);
    chk(rsp_valid === 1'b1, {tag, " R1 valid"}, 64'(rsp_valid), 64'd1);
    chk({rsp_cause, rsp_status, rsp_rep, rsp_oldspace, rsp_vol, rsp_pa} === e, tag,
        64'({rsp_cause, rsp_status, rsp_rep, rsp_oldspace, rsp_vol, rsp_pa}), 64'(e));
    chk(rsp_exc === (e[43:41] != 0), {tag, " R9 exc"}, 64'(rsp_exc), 64'(e[43:41] != 0));
    @(negedge clk);
    chk(rsp_valid === 1'b0, {tag, " R1 single"}, 64'(rsp_valid), 64'd0);
  endtask

  // set up entries for va: l1 valid/old/vol and block, l2 fields
  task automatic setup(input logic [24:0] va, input logic v, input logic [6:0] blk,
                       input logic fok, input logic [2:0] st, input logic acc, input logic [21:0] ppn);
    wr2({blk, va[12:8]}, {fok, 2'd1, st, acc, ppn});
    wr1(va[24:13], {v, 1'b1, 3'd5, blk});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(rsp_valid === 1'b0, "R1 reset rsp_valid", 64'(rsp_valid), 0);
    chk(req_ready === 1'b0, "R1 reset ready", 64'(req_ready), 0);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready === 1'b1, "R1 ready after reset", 64'(req_ready), 1);

    setup(25'h0ABCDE, 0, 7'd3, 0, 3'd4, 1, 22'h12345);
    look(25'h0ABCDE, 0, 0, "R2 l1 miss");
    setup(25'h0ABCDE, 0, 7'd3, 0, 3'd0, 1, 22'h12345);
    look(25'h0ABCDE, 1, 1, "R11 l1 miss over map miss");
    setup(25'h1F0012, 1, 7'd9, 0, 3'd4, 1, 22'h3FFFFF);
    look(25'h1F0012, 0, 0, "R4 read ok");
    look(25'h1F0012, 1, 0, "R7 write rw ok");
    setup(25'h002100, 1, 7'd127, 0, 3'd0, 1, 22'h1);
    look(25'h002100, 0, 0, "R5 map miss");
    setup(25'h002100, 1, 7'd127, 0, 3'd1, 1, 22'h1);
    look(25'h002100, 0, 0, "R5 meta only");
    setup(25'h002100, 1, 7'd127, 1, 3'd6, 0, 22'h1);
    look(25'h002100, 1, 1, "R11 special over access");
    setup(25'h123456, 1, 7'd0, 1, 3'd4, 0, 22'h2AAAA);
    look(25'h123456, 0, 0, "R6 no access read");
    setup(25'h123456, 1, 7'd0, 1, 3'd3, 1, 22'h2AAAA);
    look(25'h123456, 0, 0, "R6 read on rw-first");
    look(25'h123456, 1, 0, "R7 write rw-first");
    look(25'h123456, 1, 1, "R8 forced allowed");
    setup(25'h123456, 1, 7'd0, 0, 3'd2, 1, 22'h2AAAA);
    look(25'h123456, 1, 1, "R8 forced not allowed");
    look(25'h123456, 1, 0, "R7 write read-only");
    setup(25'h123456, 1, 7'd0, 0, 3'd4, 1, 22'h15555);
    look(25'h123456, 0, 0, "R10 rewrite seen");
    setup(25'h123457, 1, 7'd1, 0, 3'd4, 1, 22'h00F0F);
    look(25'h123457, 0, 0, "R3 block change");

    for (int i = 0; i < 400; i++) begin
      logic [24:0] va; logic [11:0] e1; logic [28:0] e2;
      va = 25'($urandom);
      e1 = 12'($urandom);
      e1[11] = ($urandom % 4) != 0;
      e2 = 29'($urandom);
      if (($urandom % 3) == 0) e2[25:23] = 3'd2 + 3'($urandom % 3);
      wr2({e1[6:0], va[12:8]}, e2);
      wr1(va[24:13], e1);
      look(va, 1'($urandom), 1'($urandom), "R3 R4 R5 R6 R7 R8 random");
    end
    finish_run();
  end
endmodule